// File: doc/BRIEF.md
# Disk Controller Busmaster Register Bank

This block sits on the IO-port bus of a two-channel disk controller. Every 16-bit IO address presented to it is classified into one of three address windows (the eight-port task file, the two-port control pair, or the eight-port busmaster block) and into the channel that window belongs to. The classification is driven out on dedicated decode outputs so that the neighbouring task-file and control logic can reuse a single decoder.

For the busmaster window the block also holds the registers itself. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. The pointer is reached through four consecutive byte ports, and the low two address bits pick the byte lane. Only single-byte accesses to mapped offsets are legal. Anything else is refused with a one-cycle error flag, and a refused access leaves all state untouched. Reads are combinational from the registers. Writes land on the clock edge of the write strobe.

Top module: `ide_bm_regbank`

## Requirements
- R1: Addresses 0x1F0-0x1F7 give dec_win=1 (task file), 0x3F6-0x3F7 give dec_win=2 (control), 0xC000-0xC007 give dec_win=3 (busmaster); all of these give dec_hit=1 and dec_chan=0.
- R2: Addresses 0x170-0x177 (dec_win=1), 0x376-0x377 (dec_win=2) and 0xC008-0xC00F (dec_win=3) give dec_hit=1 and dec_chan=1.
- R3: Every other address gives dec_hit=0, dec_win=0 and dec_chan=0. Access strobes on such addresses change no register, return io_rdata=0x00 and raise no error.
- R4: Busmaster offset 0 (addr[2:0]=0) is the channel's 8-bit command register. A legal write stores io_wdata, and a later read returns it.
- R5: Busmaster offset 2 is the channel's 8-bit status register, with the same write and read behaviour as R4.
- R6: Busmaster offsets 4-7 each reach one byte of the channel's 32-bit descriptor pointer. The lane is addr[1:0], and lane 0 is bits 7:0. A write changes only that byte, and a read returns only that byte.
- R7: The two channels hold separate registers. A write to one channel never changes the other.
- R8: A busmaster access with io_size not equal to 1 (io_size is the byte count) raises io_err in that cycle, changes no register and returns io_rdata=0x00.
- R9: A busmaster access to offset 1 or 3 raises io_err in that cycle, changes no register and returns io_rdata=0x00.
- R10: Reset (rst high at a clock edge) clears the command, status and pointer registers of both channels to zero.
- R11: io_err is low in every cycle without an io_rd or io_wr strobe. A read never changes a register, and no register changes in a cycle without a legal write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_addr | input | 16 | IO port address |
| io_size | input | 3 | Access width in bytes |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational |
| io_err | output | 1 | Access refused (busmaster window only) |
| dec_hit | output | 1 | Address falls in a known window |
| dec_chan | output | 1 | Channel owning the address |
| dec_win | output | 2 | Window: 0 none, 1 task file, 2 control, 3 busmaster |

## Verification
The assertions check the following on every cycle:
- A refused access leaves the command, status and pointer registers stable, and a refused read returns zero.
- The error flag stays low without a strobe.
- The registers stay stable in cycles without a legal write.
- A miss decodes to window zero.
- A reset edge clears everything.

Only the bench scenarios can show the behaviour that depends on address values. That includes the exact edges of each window, that the pointer byte lane follows addr[1:0] while the other three bytes keep their contents, and that the two channels stay isolated. The bench compares all outputs on every clock against its own behavioural model.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

    localparam int NUM_CHAN = 2;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_TASK = 2'd1,
        WIN_CTRL = 2'd2,
        WIN_BM   = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        BSEL_CMD  = 2'd0,
        BSEL_STS  = 2'd1,
        BSEL_PTR  = 2'd2,
        BSEL_HOLE = 2'd3
    } bm_sel_e;

    typedef struct packed {
        logic    hit;
        logic    chan;
        win_e    win;
        bm_sel_e sel;
        logic [1:0] lane;
    } dec_t;

    // Map an offset inside the 8-port busmaster window to a register select.
    function automatic bm_sel_e bm_offset_sel(input logic [2:0] off);
        bm_sel_e s;
        case (off)
            3'd0:    s = BSEL_CMD;
            3'd2:    s = BSEL_STS;
            3'd4, 3'd5, 3'd6, 3'd7: s = BSEL_PTR;
            default: s = BSEL_HOLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ide_bm_addr_dec.sv
module ide_bm_addr_dec
    import ide_bm_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] TASK0_BASE = 16'h01F0,
    parameter logic [15:0] TASK1_BASE = 16'h0170,
    parameter logic [15:0] CTRL0_BASE = 16'h03F6,
    parameter logic [15:0] CTRL1_BASE = 16'h0376,
    parameter logic [15:0] BM_BASE    = 16'hC000,
    parameter int          BM_STRIDE  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] TASK_MASK = ~ADDR_W'(7);
    localparam logic [ADDR_W-1:0] CTRL_MASK = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] BM_MASK   = ~ADDR_W'(BM_STRIDE - 1);

    logic [NUM_CHAN-1:0][ADDR_W-1:0] task_base;
    logic [NUM_CHAN-1:0][ADDR_W-1:0] ctrl_base;

    assign task_base[0] = TASK0_BASE;
    assign task_base[1] = TASK1_BASE;
    assign ctrl_base[0] = CTRL0_BASE;
    assign ctrl_base[1] = CTRL1_BASE;

    always_comb begin
        dec = '{hit: 1'b0, chan: 1'b0, win: WIN_NONE, sel: BSEL_HOLE, lane: addr[1:0]};
        for (int c = 0; c < NUM_CHAN; c++) begin
            if ((addr & TASK_MASK) == task_base[c]) begin
                dec.hit  = 1'b1;
                dec.chan = c[0];
                dec.win  = WIN_TASK;
            end else if ((addr & CTRL_MASK) == ctrl_base[c]) begin
                dec.hit  = 1'b1;
                dec.chan = c[0];
                dec.win  = WIN_CTRL;
            end else if ((addr & BM_MASK) == BM_BASE + ADDR_W'(c * BM_STRIDE)) begin
                dec.hit  = 1'b1;
                dec.chan = c[0];
                dec.win  = WIN_BM;
                dec.sel  = bm_offset_sel(addr[2:0]);
            end
        end
    end
endmodule

// File: rtl/ide_bm_chan_regs.sv
module ide_bm_chan_regs #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we_cmd,
    input  logic                       we_sts,
    input  logic                       we_ptr,
    input  logic [$clog2(PTR_W/DATA_W)-1:0] lane,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          cmd_q,
    output logic [DATA_W-1:0]          sts_q,
    output logic [PTR_W-1:0]           ptr_q
);
    localparam int LANES = PTR_W / DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            sts_q <= '0;
        end else begin
            if (we_cmd) cmd_q <= wdata;
            if (we_sts) sts_q <= wdata;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[g*DATA_W +: DATA_W] <= '0;
            else if (we_ptr && (int'(lane) == g))
                ptr_q[g*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/ide_bm_rd_mux.sv
module ide_bm_rd_mux
    import ide_bm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 32
) (
    input  dec_t                         dec,
    input  logic                         rd_ok,
    input  logic [NUM_CHAN*DATA_W-1:0]   cmd_flat,
    input  logic [NUM_CHAN*DATA_W-1:0]   sts_flat,
    input  logic [NUM_CHAN*PTR_W-1:0]    ptr_flat,
    output logic [DATA_W-1:0]            rdata
);
    logic [PTR_W-1:0] ptr_sel;

    always_comb begin
        ptr_sel = ptr_flat[dec.chan*PTR_W +: PTR_W];
        rdata   = '0;
        if (rd_ok) begin
            case (dec.sel)
                BSEL_CMD: rdata = cmd_flat[dec.chan*DATA_W +: DATA_W];
                BSEL_STS: rdata = sts_flat[dec.chan*DATA_W +: DATA_W];
                BSEL_PTR: rdata = ptr_sel[dec.lane*DATA_W +: DATA_W];
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ide_bm_regbank.sv
module ide_bm_regbank
    import ide_bm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [2:0]        io_size,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_err,
    output logic              dec_hit,
    output logic              dec_chan,
    output logic [1:0]        dec_win
);
    localparam int LANE_W = $clog2(PTR_W / DATA_W);

    dec_t dec;
    logic in_bm, legal, wr_ok, rd_ok;
    logic [NUM_CHAN*DATA_W-1:0] cmd_flat;
    logic [NUM_CHAN*DATA_W-1:0] sts_flat;
    logic [NUM_CHAN*PTR_W-1:0]  ptr_flat;

    ide_bm_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (io_addr),
        .dec  (dec)
    );

    assign in_bm = (dec.win == WIN_BM);
    assign legal = in_bm && (io_size == 3'd1) && (dec.sel != BSEL_HOLE);
    assign wr_ok = io_wr && legal;
    assign rd_ok = io_rd && legal;
    assign io_err = (io_rd || io_wr) && in_bm && !legal;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic hit_c;
        assign hit_c = wr_ok && (int'(dec.chan) == c);
        ide_bm_chan_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .we_cmd (hit_c && (dec.sel == BSEL_CMD)),
            .we_sts (hit_c && (dec.sel == BSEL_STS)),
            .we_ptr (hit_c && (dec.sel == BSEL_PTR)),
            .lane   (dec.lane[LANE_W-1:0]),
            .wdata  (io_wdata),
            .cmd_q  (cmd_flat[c*DATA_W +: DATA_W]),
            .sts_q  (sts_flat[c*DATA_W +: DATA_W]),
            .ptr_q  (ptr_flat[c*PTR_W +: PTR_W])
        );
    end

    ide_bm_rd_mux #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_rd (
        .dec      (dec),
        .rd_ok    (rd_ok),
        .cmd_flat (cmd_flat),
        .sts_flat (sts_flat),
        .ptr_flat (ptr_flat),
        .rdata    (io_rdata)
    );

    assign dec_hit  = dec.hit;
    assign dec_chan = dec.chan;
    assign dec_win  = dec.win;
endmodule

// File: rtl/ide_bm_regbank_chk.sv
module ide_bm_regbank_chk #(
    parameter int W_CS = 16,
    parameter int W_P  = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            io_rd,
    input logic            io_wr,
    input logic [7:0]      io_rdata,
    input logic            io_err,
    input logic            dec_hit,
    input logic            dec_chan,
    input logic [1:0]      dec_win,
    input logic            wr_ok,
    input logic [W_CS-1:0] cmd_flat,
    input logic [W_CS-1:0] sts_flat,
    input logic [W_P-1:0]  ptr_flat
);
    // R8 / R9: refused accesses leave all state untouched
    p_err_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
        io_err |=> ($stable(cmd_flat) && $stable(sts_flat) && $stable(ptr_flat)));

    // R9: refused read returns zero
    p_err_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (io_err && io_rd) |-> (io_rdata == 8'h00));

    // R11: no strobe, no error
    p_no_strobe_no_err_r11: assert property (@(posedge clk) disable iff (rst)
        !(io_rd || io_wr) |-> !io_err);

    // R11: state only moves on a legal write
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> ($stable(cmd_flat) && $stable(sts_flat) && $stable(ptr_flat)));

    // R3: a miss reports no window and channel 0
    p_miss_window_r3: assert property (@(posedge clk) disable iff (rst)
        !dec_hit |-> (dec_win == 2'd0 && !dec_chan));

    // R10: a reset edge clears everything
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (cmd_flat == '0 && sts_flat == '0 && ptr_flat == '0));
endmodule

bind ide_bm_regbank ide_bm_regbank_chk #(
    .W_CS(ide_bm_pkg::NUM_CHAN * DATA_W),
    .W_P (ide_bm_pkg::NUM_CHAN * PTR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_rdata (io_rdata),
    .io_err   (io_err),
    .dec_hit  (dec_hit),
    .dec_chan (dec_chan),
    .dec_win  (dec_win),
    .wr_ok    (wr_ok),
    .cmd_flat (cmd_flat),
    .sts_flat (sts_flat),
    .ptr_flat (ptr_flat)
);

// File: tb/ide_bm_regbank_tb.sv
module ide_bm_regbank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [2:0]  io_size = 3'd1;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        io_err;
    logic        dec_hit;
    logic        dec_chan;
    logic [1:0]  dec_win;

    int compared = 0;
    int mismatched = 0;

    // behavioural model state
    logic [7:0] m_cmd [2];
    logic [7:0] m_sts [2];
    logic [7:0] m_ptr [2][4];

    always #5 clk = ~clk;

    ide_bm_regbank u_dut (
        .clk(clk), .rst(rst), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
        .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_err(io_err),
        .dec_hit(dec_hit), .dec_chan(dec_chan), .dec_win(dec_win)
    );

    function automatic void classify(input logic [15:0] a, output int win, output int ch);
        win = 0; ch = 0;
        if (a >= 16'h01F0 && a <= 16'h01F7) begin win = 1; ch = 0; end
        else if (a >= 16'h0170 && a <= 16'h0177) begin win = 1; ch = 1; end
        else if (a == 16'h03F6 || a == 16'h03F7) begin win = 2; ch = 0; end
        else if (a == 16'h0376 || a == 16'h0377) begin win = 2; ch = 1; end
        else if (a >= 16'hC000 && a <= 16'hC007) begin win = 3; ch = 0; end
        else if (a >= 16'hC008 && a <= 16'hC00F) begin win = 3; ch = 1; end
    endfunction

    function automatic bit model_legal();
        int w, c, off;
        classify(io_addr, w, c);
        off = int'(io_addr) % 8;
        return (w == 3) && (io_size == 3'd1) && (off != 1) && (off != 3);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h (addr %h)", tag, what, act, exp, io_addr);
        end
    endtask

    task automatic compare_all(input string tag);
        int w, c, off, er, rd;
        classify(io_addr, w, c);
        off = int'(io_addr) % 8;
        er = ((io_rd || io_wr) && w == 3 && !model_legal()) ? 1 : 0;
        rd = 0;
        if (io_rd && model_legal()) begin
            if (off == 0) rd = m_cmd[c];
            else if (off == 2) rd = m_sts[c];
            else rd = m_ptr[c][off-4];
        end
        check(tag, "dec_hit", dec_hit, (w != 0) ? 1 : 0);
        check(tag, "dec_win", dec_win, w);
        check(tag, "dec_chan", dec_chan, c);
        check(tag, "io_err", io_err, er);
        check(tag, "io_rdata", io_rdata, rd);
    endtask

    task automatic model_clock();
        int w, c, off;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_cmd[i] = 8'h00; m_sts[i] = 8'h00;
                for (int j = 0; j < 4; j++) m_ptr[i][j] = 8'h00;
            end
        end else if (io_wr && model_legal()) begin
            classify(io_addr, w, c);
            off = int'(io_addr) % 8;
            if (off == 0) m_cmd[c] = io_wdata;
            else if (off == 2) m_sts[c] = io_wdata;
            else m_ptr[c][off-4] = io_wdata;
        end
    endtask

    // one clock: compare at falling edge, model follows rising edge
    task automatic step(input string tag);
        @(negedge clk);
        compare_all(tag);
        @(posedge clk);
        model_clock();
        #1;
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic acc(input bit wr, input bit rd, input logic [15:0] a,
                       input logic [7:0] d, input logic [2:0] s, input string tag);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; io_size = s;
        step(tag);
    endtask

    task automatic rd_all(input string tag);
        for (int c = 0; c < 2; c++) begin
            acc(0, 1, 16'hC000 + 16'(c*8), 8'h00, 3'd1, tag);
            acc(0, 1, 16'hC002 + 16'(c*8), 8'h00, 3'd1, tag);
            for (int l = 0; l < 4; l++)
                acc(0, 1, 16'hC004 + 16'(c*8 + l), 8'h00, 3'd1, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // model starts with X-free zero only after reset edge
        repeat (3) begin @(posedge clk); model_clock(); end
        #1 rst = 1'b0;

        // R10: reset state
        rd_all("R10");

        // R1 / R2 / R3: decode sweep with edges
        acc(0, 0, 16'h01F0, 0, 1, "R1"); acc(0, 0, 16'h01F7, 0, 1, "R1");
        acc(0, 0, 16'h03F6, 0, 1, "R1"); acc(0, 0, 16'h03F7, 0, 1, "R1");
        acc(0, 0, 16'hC000, 0, 1, "R1"); acc(0, 0, 16'hC007, 0, 1, "R1");
        acc(0, 0, 16'h0170, 0, 1, "R2"); acc(0, 0, 16'h0177, 0, 1, "R2");
        acc(0, 0, 16'h0376, 0, 1, "R2"); acc(0, 0, 16'h0377, 0, 1, "R2");
        acc(0, 0, 16'hC008, 0, 1, "R2"); acc(0, 0, 16'hC00F, 0, 1, "R2");
        acc(0, 0, 16'h01F8, 0, 1, "R3"); acc(0, 0, 16'h03F5, 0, 1, "R3");
        acc(0, 0, 16'h03F8, 0, 1, "R3"); acc(0, 0, 16'hC010, 0, 1, "R3");
        acc(0, 0, 16'hBFFF, 0, 1, "R3"); acc(0, 0, 16'h0378, 0, 1, "R3");
        acc(0, 0, 16'h41F0, 0, 1, "R3"); acc(0, 0, 16'h016F, 0, 1, "R3");
        // R3: strobes outside the busmaster window do nothing
        acc(1, 1, 16'h01F0, 8'hEE, 1, "R3"); acc(1, 1, 16'h03F6, 8'hEE, 2, "R3");
        acc(1, 1, 16'h1234, 8'hEE, 1, "R3");
        rd_all("R3");

        // R4 / R7: command registers
        acc(1, 0, 16'hC000, 8'hA5, 1, "R4");
        acc(0, 1, 16'hC000, 0, 1, "R4");
        acc(0, 1, 16'hC008, 0, 1, "R7");
        acc(1, 0, 16'hC008, 8'h3C, 1, "R4");
        acc(0, 1, 16'hC008, 0, 1, "R4");
        acc(0, 1, 16'hC000, 0, 1, "R7");

        // R5: status registers
        acc(1, 0, 16'hC002, 8'h81, 1, "R5");
        acc(1, 0, 16'hC00A, 8'h7E, 1, "R5");
        acc(0, 1, 16'hC002, 0, 1, "R5");
        acc(0, 1, 16'hC00A, 0, 1, "R5");

        // R6: pointer lanes, one at a time
        acc(1, 0, 16'hC006, 8'h22, 1, "R6");
        rd_all("R6");
        acc(1, 0, 16'hC004, 8'h11, 1, "R6");
        acc(1, 0, 16'hC005, 8'h33, 1, "R6");
        acc(1, 0, 16'hC007, 8'h44, 1, "R6");
        acc(1, 0, 16'hC00D, 8'hBE, 1, "R6");
        acc(1, 0, 16'hC00F, 8'hEF, 1, "R6");
        acc(1, 0, 16'hC006, 8'h99, 1, "R6");
        rd_all("R6");

        // R8: wrong size refused
        acc(1, 0, 16'hC000, 8'h55, 2, "R8");
        acc(1, 0, 16'hC004, 8'h55, 4, "R8");
        acc(1, 1, 16'hC00A, 8'h55, 0, "R8");
        acc(0, 1, 16'hC002, 0, 4, "R8");
        rd_all("R8");

        // R9: unmapped holes refused
        acc(1, 0, 16'hC001, 8'h66, 1, "R9");
        acc(1, 0, 16'hC00B, 8'h66, 1, "R9");
        acc(0, 1, 16'hC003, 0, 1, "R9");
        acc(0, 1, 16'hC009, 0, 1, "R9");
        rd_all("R9");

        // R11: idle cycles and repeated reads change nothing
        repeat (4) begin io_addr = 16'hC001; io_size = 3'd2; step("R11"); end
        acc(0, 1, 16'hC004, 0, 1, "R11");
        acc(0, 1, 16'hC004, 0, 1, "R11");
        rd_all("R11");

        // R10: mid-run reset
        rst = 1'b1;
        step("R10");
        #1 rst = 1'b0;
        rd_all("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule